// File: doc/BRIEF.md
# Power-Delivery Transmit Message Sequencer

This block runs the transmit side of one power-delivery message at a time. Software gives a send command with a 2-bit message type and a payload byte count. For a normal packet the block then asks for payload bytes one at a time. Each byte is held in a single-entry data register until the serializer takes it, and a 10-bit remaining-byte counter goes down on every accepted write. A hard-reset command has priority over any message that is in flight. In that case the block raises an aborted flag, keeps the sent flag low, and switches the line to a hard-reset frame. A message that cannot start, either because the receiver is busy or because the type code is invalid, is dropped. Its discarded flag is raised only once the line is idle again.

Two valid/ready streams carry the data. Software writes bytes on `wr_valid`/`data_req`, and the serializer takes them on `byte_valid`/`byte_ready`. On both streams a transfer happens in any cycle where both sides are high. `byte_valid` and `byte_data` stay stable until the serializer accepts. The serializer raises `byte_ready` only in the cycle its slot for the next byte falls due. If `byte_ready` is high while no byte is held and bytes are still owed, that is an underrun. The serializer pulses `ser_done` when a frame's trailer has gone out. Encoding, CRC and the line driver are outside the block. All outputs come from registers.

Top module: `pd_tx_sequencer`

## Requirements
- R1: While `rst_n` is low, or in the cycle after `enable` is sampled low, the following are all 0: both pending bits, `data_req`, `byte_valid`, `tx_active` and every status flag. Enable low also quits any frame in progress, BIST included.
- R2: An accepted send loads `pay_size` (10 bits, header bytes included, CRC excluded) into the remaining counter. `data_req` is high only during a packet, with the data register empty and the counter nonzero. A write (`wr_valid` and `data_req`) fills the register, drops `data_req` and decrements the counter.
- R3: `byte_valid` is high exactly while a packet holds a byte. `byte_data` keeps the written value until `byte_ready` is seen, and consuming the byte empties the register.
- R4: `send_pending` is set by `send_cmd` only when idle with no hard reset pending. `hrst_pending` is set by `hrst_cmd` when no hard-reset frame is active. Each clears itself in the cycle its request starts or is discarded.
- R5: `tx_mode` 0 starts a packet, 1 a cable-reset frame and 2 a BIST carrier. `tx_kind` reports 0 for a packet, 1 for cable reset, 2 for BIST and 3 for hard reset while `tx_active` is high.
- R6: `tx_mode` 3 is invalid. The request is dropped, `tx_active` never rises, and `flag_disc` is set once the line is idle.
- R7: A send that finds `line_busy` high is dropped. `flag_disc` rises one cycle after `line_busy` is first sampled low, and not before.
- R8: During a packet, `byte_ready` with an empty register and a nonzero counter sets `flag_underrun` and ends the packet without setting `flag_sent`.
- R9: `ser_done` ends a packet or cable-reset frame and sets `flag_sent`. It ends a hard-reset frame and sets `flag_hrst_sent`.
- R10: A hard reset pending while a packet, cable-reset or BIST frame is active sets `flag_abort`. It switches `tx_kind` to 3 the next cycle, empties the data register and never sets `flag_sent` for the interrupted frame.
- R11: A hard reset taken up while idle with `line_busy` high sets `flag_hrst_disc` and drives no frame.
- R12: A BIST carrier ignores `ser_done` and runs until a hard reset or until enable is cleared.
- R13: Flags are sticky. `flag_clr` bit 0 clears sent, bit 1 discarded, bit 2 aborted, bit 3 hard-reset sent, bit 4 hard-reset discarded and bit 5 underrun. A set in the same cycle wins over a clear.
- R14: When idle with both requests pending, the hard reset goes first and the send stays pending until it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low clears all state |
| send_cmd | input | 1 | Send request strobe |
| hrst_cmd | input | 1 | Hard-reset request strobe |
| tx_mode | input | 2 | Message type for a send |
| pay_size | input | 10 | Payload byte count for a send |
| line_busy | input | 1 | Receive in progress or line not idle |
| wr_valid | input | 1 | Software byte write valid |
| wr_data | input | 8 | Software byte |
| data_req | output | 1 | Data-request flag, also write ready |
| byte_valid | output | 1 | Byte available to serializer |
| byte_data | output | 8 | Byte to serializer |
| byte_ready | input | 1 | Serializer takes a byte |
| ser_done | input | 1 | Serializer finished the frame |
| flag_clr | input | 6 | Write-one clear strobes for the flags |
| send_pending | output | 1 | Send command bit |
| hrst_pending | output | 1 | Hard-reset command bit |
| tx_active | output | 1 | A frame is on the line |
| tx_kind | output | 2 | Type of active frame |
| flag_sent | output | 1 | Message sent |
| flag_disc | output | 1 | Message discarded |
| flag_abort | output | 1 | Message aborted by hard reset |
| flag_hrst_sent | output | 1 | Hard reset sent |
| flag_hrst_disc | output | 1 | Hard reset discarded |
| flag_underrun | output | 1 | Transmit underrun |

## Verification
A command strobe shows up on its pending bit one clock later. The frame it starts, or the drop decision, follows one clock after that, and a dropped message's flag comes one clock after `line_busy` is seen low. A write, a consume, an underrun or `ser_done` takes effect on the outputs at the next clock edge. The bench's reference model advances once per rising edge from the inputs held over that cycle. It compares every output 2 ns after the edge, and the directed checks count edges the same way, sampling at the falling edge. Stimulus changes only at falling edges.

// File: rtl/pd_tx_pkg.sv
package pd_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DISC = 3'd1,
    ST_PKT  = 3'd2,
    ST_CRST = 3'd3,
    ST_BIST = 3'd4,
    ST_HRST = 3'd5
  } tx_state_e;

  typedef enum logic [1:0] {
    KIND_PKT  = 2'd0,
    KIND_CRST = 2'd1,
    KIND_BIST = 2'd2,
    KIND_HRST = 2'd3
  } tx_kind_e;

  localparam int NUM_FLAGS = 6;
  localparam int FL_SENT   = 0;
  localparam int FL_DISC   = 1;
  localparam int FL_ABORT  = 2;
  localparam int FL_HSENT  = 3;
  localparam int FL_HDISC  = 4;
  localparam int FL_UNDER  = 5;

  localparam logic [1:0] MODE_PKT  = 2'd0;
  localparam logic [1:0] MODE_CRST = 2'd1;
  localparam logic [1:0] MODE_BIST = 2'd2;
  localparam logic [1:0] MODE_BAD  = 2'd3;

endpackage

// File: rtl/pd_tx_cmd.sv
module pd_tx_cmd #(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              send_cmd,
  input  logic              hrst_cmd,
  input  logic [MODE_W-1:0] tx_mode,
  input  logic              send_ok,
  input  logic              hrst_ok,
  input  logic              send_take,
  input  logic              hrst_take,
  output logic              send_pend,
  output logic              hrst_pend,
  output logic              send_accept,
  output logic [MODE_W-1:0] mode_q
);

  assign send_accept = enable && send_cmd && send_ok && !send_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      send_pend <= 1'b0;
      hrst_pend <= 1'b0;
      mode_q    <= '0;
    end else if (!enable) begin
      send_pend <= 1'b0;
      hrst_pend <= 1'b0;
      mode_q    <= '0;
    end else begin
      if (send_take) begin
        send_pend <= 1'b0;
      end else if (send_accept) begin
        send_pend <= 1'b1;
        mode_q    <= tx_mode;
      end
      if (hrst_take) begin
        hrst_pend <= 1'b0;
      end else if (hrst_cmd && hrst_ok && !hrst_pend) begin
        hrst_pend <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pd_tx_payload.sv
module pd_tx_payload #(
  parameter int CNT_W  = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_val,
  input  logic              clr,
  input  logic              in_pkt,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              byte_ready,
  output logic              data_req,
  output logic              byte_valid,
  output logic [DATA_W-1:0] byte_data,
  output logic              starve
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic              full_q;
  logic [CNT_W-1:0]  remain_q;
  logic [DATA_W-1:0] data_q;
  logic              owed;
  logic              wr_fire;
  logic              rd_fire;

  assign owed       = (remain_q != CNT_ZERO);
  assign data_req   = in_pkt && !full_q && owed;
  assign byte_valid = in_pkt && full_q;
  assign byte_data  = data_q;
  assign wr_fire    = data_req && wr_valid;
  assign rd_fire    = byte_valid && byte_ready;
  assign starve     = in_pkt && byte_ready && !full_q && owed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q   <= 1'b0;
      remain_q <= CNT_ZERO;
      data_q   <= '0;
    end else if (!enable || clr) begin
      full_q   <= 1'b0;
      remain_q <= CNT_ZERO;
    end else begin
      if (load) begin
        remain_q <= load_val;
      end
      if (wr_fire) begin
        full_q   <= 1'b1;
        data_q   <= wr_data;
        remain_q <= remain_q - CNT_ONE;
      end else if (rd_fire) begin
        full_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pd_tx_fsm.sv
module pd_tx_fsm
  import pd_tx_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 send_pend,
  input  logic                 hrst_pend,
  input  logic [MODE_W-1:0]    mode_q,
  input  logic                 line_busy,
  input  logic                 ser_done,
  input  logic                 starve,
  output tx_state_e            state,
  output logic                 send_take,
  output logic                 hrst_take,
  output logic                 pay_clr,
  output logic [NUM_FLAGS-1:0] ev
);

  tx_state_e nxt;
  logic      framing;

  assign framing = (state == ST_PKT) || (state == ST_CRST) || (state == ST_BIST);

  always_comb begin
    nxt       = state;
    send_take = 1'b0;
    hrst_take = 1'b0;
    pay_clr   = 1'b0;
    ev        = '0;
    if (state == ST_IDLE) begin
      if (hrst_pend) begin
        hrst_take = 1'b1;
        if (line_busy) ev[FL_HDISC] = 1'b1;
        else           nxt = ST_HRST;
      end else if (send_pend) begin
        send_take = 1'b1;
        if (mode_q == MODE_BAD || line_busy) begin
          nxt = ST_DISC;
        end else begin
          case (mode_q)
            MODE_CRST: nxt = ST_CRST;
            MODE_BIST: nxt = ST_BIST;
            default:   nxt = ST_PKT;
          endcase
        end
      end
    end else if (state == ST_DISC) begin
      if (!line_busy) begin
        ev[FL_DISC] = 1'b1;
        nxt         = ST_IDLE;
      end
    end else if (framing) begin
      if (hrst_pend) begin
        hrst_take     = 1'b1;
        ev[FL_ABORT]  = 1'b1;
        pay_clr       = 1'b1;
        nxt           = ST_HRST;
      end else if (state == ST_PKT && starve) begin
        ev[FL_UNDER] = 1'b1;
        pay_clr      = 1'b1;
        nxt          = ST_IDLE;
      end else if (state != ST_BIST && ser_done) begin
        ev[FL_SENT] = 1'b1;
        pay_clr     = 1'b1;
        nxt         = ST_IDLE;
      end
    end else if (state == ST_HRST) begin
      if (ser_done) begin
        ev[FL_HSENT] = 1'b1;
        nxt          = ST_IDLE;
      end
    end else begin
      nxt = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state <= ST_IDLE;
    else if (!enable) state <= ST_IDLE;
    else              state <= nxt;
  end

endmodule

// File: rtl/pd_tx_flags.sv
module pd_tx_flags #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic [N-1:0] ev,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flags[i] <= 1'b0;
      else if (!enable) flags[i] <= 1'b0;
      else if (ev[i])   flags[i] <= 1'b1;
      else if (clr[i])  flags[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/pd_tx_sequencer.sv
module pd_tx_sequencer
  import pd_tx_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int DATA_W = 8,
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              send_cmd,
  input  logic              hrst_cmd,
  input  logic [MODE_W-1:0] tx_mode,
  input  logic [CNT_W-1:0]  pay_size,
  input  logic              line_busy,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              data_req,
  output logic              byte_valid,
  output logic [DATA_W-1:0] byte_data,
  input  logic              byte_ready,
  input  logic              ser_done,
  input  logic [5:0]        flag_clr,
  output logic              send_pending,
  output logic              hrst_pending,
  output logic              tx_active,
  output logic [1:0]        tx_kind,
  output logic              flag_sent,
  output logic              flag_disc,
  output logic              flag_abort,
  output logic              flag_hrst_sent,
  output logic              flag_hrst_disc,
  output logic              flag_underrun
);

  tx_state_e             state;
  logic                  send_take, hrst_take, pay_clr, starve, send_accept;
  logic [MODE_W-1:0]     mode_q;
  logic [NUM_FLAGS-1:0]  ev, flags;

  pd_tx_cmd #(.MODE_W(MODE_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .send_cmd(send_cmd), .hrst_cmd(hrst_cmd), .tx_mode(tx_mode),
    .send_ok(state == ST_IDLE && !hrst_pending),
    .hrst_ok(state != ST_HRST),
    .send_take(send_take), .hrst_take(hrst_take),
    .send_pend(send_pending), .hrst_pend(hrst_pending),
    .send_accept(send_accept), .mode_q(mode_q)
  );

  pd_tx_payload #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_pay (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .load(send_accept), .load_val(pay_size), .clr(pay_clr),
    .in_pkt(state == ST_PKT),
    .wr_valid(wr_valid), .wr_data(wr_data), .byte_ready(byte_ready),
    .data_req(data_req), .byte_valid(byte_valid), .byte_data(byte_data),
    .starve(starve)
  );

  pd_tx_fsm #(.MODE_W(MODE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .send_pend(send_pending), .hrst_pend(hrst_pending), .mode_q(mode_q),
    .line_busy(line_busy), .ser_done(ser_done), .starve(starve),
    .state(state), .send_take(send_take), .hrst_take(hrst_take),
    .pay_clr(pay_clr), .ev(ev)
  );

  pd_tx_flags #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .ev(ev), .clr(flag_clr), .flags(flags)
  );

  always_comb begin
    tx_active = 1'b1;
    case (state)
      ST_PKT:  tx_kind = KIND_PKT;
      ST_CRST: tx_kind = KIND_CRST;
      ST_BIST: tx_kind = KIND_BIST;
      ST_HRST: tx_kind = KIND_HRST;
      default: begin
        tx_kind   = KIND_PKT;
        tx_active = 1'b0;
      end
    endcase
  end

  assign flag_sent      = flags[FL_SENT];
  assign flag_disc      = flags[FL_DISC];
  assign flag_abort     = flags[FL_ABORT];
  assign flag_hrst_sent = flags[FL_HSENT];
  assign flag_hrst_disc = flags[FL_HDISC];
  assign flag_underrun  = flags[FL_UNDER];

endmodule

// File: rtl/pd_tx_sequencer_chk.sv
module pd_tx_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       wr_valid,
  input logic       data_req,
  input logic       byte_valid,
  input logic [7:0] byte_data,
  input logic       byte_ready,
  input logic       ser_done,
  input logic       send_pending,
  input logic       hrst_pending,
  input logic       tx_active,
  input logic [1:0] tx_kind,
  input logic       flag_sent,
  input logic       flag_abort,
  input logic       flag_hrst_sent,
  input logic       flag_underrun,
  input logic       flag_disc,
  input logic       flag_hrst_disc
);

  // R1
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !tx_active && !flag_sent && !flag_disc && !flag_abort
                && !flag_hrst_sent && !flag_hrst_disc && !flag_underrun);

  // R2
  one_write_per_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_req && wr_valid |=> !data_req);

  // R3
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !byte_ready && enable && !hrst_pending && !ser_done
      |=> byte_valid && $stable(byte_data));

  // R4
  send_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable && send_pending && !hrst_pending && !tx_active |=> !send_pending);

  // R8
  underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_underrun) |-> $past(byte_ready && !byte_valid));

  // R9
  hrst_sent_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_hrst_sent) |-> $past(tx_active && tx_kind == 2'd3));

  // R10
  abort_not_sent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_abort) |-> !$rose(flag_sent));

endmodule

bind pd_tx_sequencer pd_tx_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .wr_valid(wr_valid),
  .data_req(data_req), .byte_valid(byte_valid), .byte_data(byte_data),
  .byte_ready(byte_ready), .ser_done(ser_done),
  .send_pending(send_pending), .hrst_pending(hrst_pending),
  .tx_active(tx_active), .tx_kind(tx_kind),
  .flag_sent(flag_sent), .flag_abort(flag_abort),
  .flag_hrst_sent(flag_hrst_sent), .flag_underrun(flag_underrun),
  .flag_disc(flag_disc), .flag_hrst_disc(flag_hrst_disc)
);

// File: tb/pd_tx_sequencer_bench.sv
`timescale 1ns/1ps
module pd_tx_sequencer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       send_cmd = 1'b0, hrst_cmd = 1'b0;
  logic [1:0] tx_mode = 2'd0;
  logic [9:0] pay_size = 10'd0;
  logic       line_busy = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       byte_ready = 1'b0, ser_done = 1'b0;
  logic [5:0] flag_clr = 6'd0;
  logic       data_req, byte_valid, send_pending, hrst_pending, tx_active;
  logic [7:0] byte_data;
  logic [1:0] tx_kind;
  logic       flag_sent, flag_disc, flag_abort, flag_hrst_sent, flag_hrst_disc, flag_underrun;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pd_tx_sequencer u_pd_tx_sequencer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .send_cmd(send_cmd),
    .hrst_cmd(hrst_cmd), .tx_mode(tx_mode), .pay_size(pay_size),
    .line_busy(line_busy), .wr_valid(wr_valid), .wr_data(wr_data),
    .data_req(data_req), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .ser_done(ser_done), .flag_clr(flag_clr),
    .send_pending(send_pending), .hrst_pending(hrst_pending),
    .tx_active(tx_active), .tx_kind(tx_kind), .flag_sent(flag_sent),
    .flag_disc(flag_disc), .flag_abort(flag_abort),
    .flag_hrst_sent(flag_hrst_sent), .flag_hrst_disc(flag_hrst_disc),
    .flag_underrun(flag_underrun)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: phase 0 idle, 1 waiting to drop, 2 packet,
  // 3 cable reset, 4 BIST, 5 hard reset.
  int   ph = 0;
  bit   m_sp = 0, m_hp = 0, m_full = 0;
  int   m_mode = 0, m_rem = 0, m_data = 0;
  bit   m_fl[6] = '{default: 0};

  function automatic int kind_of(int p);
    return (p == 2) ? 0 : (p == 3) ? 1 : (p == 4) ? 2 : (p == 5) ? 3 : 0;
  endfunction

  task automatic model_step();
    bit ev[6] = '{default: 0};
    int np = ph;
    bit tk_s = 0, tk_h = 0, clr = 0;
    bit dreq = (ph == 2) && !m_full && m_rem != 0;
    bit hungry = (ph == 2) && byte_ready && !m_full && m_rem != 0;
    bit send_ok = (ph == 0) && !m_hp;
    if (!enable) begin
      ph = 0; m_sp = 0; m_hp = 0; m_full = 0; m_rem = 0; m_mode = 0;
      foreach (m_fl[i]) m_fl[i] = 0;
      return;
    end
    if (ph == 0) begin
      if (m_hp) begin
        tk_h = 1;
        if (line_busy) ev[4] = 1; else np = 5;
      end else if (m_sp) begin
        tk_s = 1;
        if (m_mode == 3 || line_busy) np = 1;
        else np = (m_mode == 1) ? 3 : (m_mode == 2) ? 4 : 2;
      end
    end else if (ph == 1) begin
      if (!line_busy) begin ev[1] = 1; np = 0; end
    end else if (ph >= 2 && ph <= 4) begin
      if (m_hp) begin tk_h = 1; ev[2] = 1; clr = 1; np = 5; end
      else if (hungry) begin ev[5] = 1; clr = 1; np = 0; end
      else if (ph != 4 && ser_done) begin ev[0] = 1; clr = 1; np = 0; end
    end else if (ph == 5) begin
      if (ser_done) begin ev[3] = 1; np = 0; end
    end
    if (clr) begin
      m_full = 0; m_rem = 0;
    end else if (dreq && wr_valid) begin
      m_full = 1; m_data = wr_data; m_rem = m_rem - 1;
    end else if (ph == 2 && m_full && byte_ready) begin
      m_full = 0;
    end
    if (tk_s) m_sp = 0;
    else if (send_cmd && send_ok && !m_sp) begin
      m_sp = 1; m_mode = tx_mode; m_rem = pay_size;
    end
    if (tk_h) m_hp = 0;
    else if (hrst_cmd && ph != 5 && !m_hp) m_hp = 1;
    foreach (m_fl[i]) if (ev[i]) m_fl[i] = 1; else if (flag_clr[i]) m_fl[i] = 0;
    ph = np;
  endtask

  always begin
    @(posedge clk);
    if (!rst_n) begin
      ph = 0; m_sp = 0; m_hp = 0; m_full = 0; m_rem = 0;
      foreach (m_fl[i]) m_fl[i] = 0;
    end else begin
      model_step();
    end
    #2;
    check("R4 send_pending", send_pending, m_sp);
    check("R4 hrst_pending", hrst_pending, m_hp);
    check("R2 data_req", data_req, (ph == 2) && !m_full && m_rem != 0);
    check("R3 byte_valid", byte_valid, (ph == 2) && m_full);
    if (byte_valid) check("R3 byte_data", byte_data, m_data);
    check("R5 tx_active", tx_active, ph >= 2);
    if (tx_active) check("R5 tx_kind", tx_kind, kind_of(ph));
    check("R9 flag_sent", flag_sent, m_fl[0]);
    check("R7 flag_disc", flag_disc, m_fl[1]);
    check("R10 flag_abort", flag_abort, m_fl[2]);
    check("R9 flag_hrst_sent", flag_hrst_sent, m_fl[3]);
    check("R11 flag_hrst_disc", flag_hrst_disc, m_fl[4]);
    check("R8 flag_underrun", flag_underrun, m_fl[5]);
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    flag_clr = 6'h3F; cyc(); flag_clr = 6'h00;
  endtask

  task automatic send(input logic [1:0] m, input int sz);
    tx_mode = m; pay_size = 10'(sz); send_cmd = 1'b1; cyc(); send_cmd = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    // R1 reset state
    check("R1 reset data_req", data_req, 0);
    check("R1 reset tx_active", tx_active, 0);
    check("R1 reset flags", {flag_sent, flag_disc, flag_abort, flag_hrst_sent,
                             flag_hrst_disc, flag_underrun}, 0);
    rst_n = 1'b1; enable = 1'b1; cyc(2);

    // R2 R3 R9: three-byte packet
    send(2'd0, 3);
    check("R4 send latched", send_pending, 1);
    cyc();
    check("R4 send cleared at start", send_pending, 0);
    check("R2 request first byte", data_req, 1);
    wr_valid = 1'b1; wr_data = 8'hA1; cyc(); wr_valid = 1'b0;
    check("R2 request dropped by write", data_req, 0);
    check("R3 byte offered", byte_data, 8'hA1);
    cyc();
    check("R3 byte held", byte_valid, 1);
    byte_ready = 1'b1; cyc(); byte_ready = 1'b0;
    check("R3 register emptied", byte_valid, 0);
    for (int k = 0; k < 2; k++) begin
      wr_valid = 1'b1; wr_data = 8'(8'hB0 + k); cyc(); wr_valid = 1'b0;
      byte_ready = 1'b1; cyc(); byte_ready = 1'b0;
    end
    check("R2 no request at count zero", data_req, 0);
    ser_done = 1'b1; cyc(); ser_done = 1'b0;
    check("R9 packet sent", flag_sent, 1);
    flag_clr = 6'b000001; cyc(); flag_clr = 6'b0;
    check("R13 sent cleared by bit 0", flag_sent, 0);

    // R8 underrun
    send(2'd0, 2); cyc();
    byte_ready = 1'b1; cyc(); byte_ready = 1'b0;
    check("R8 underrun set", flag_underrun, 1);
    check("R8 packet ended", tx_active, 0);
    check("R8 no sent", flag_sent, 0);
    clear_all();

    // R6 invalid mode
    send(2'd3, 1);
    cyc(); check("R6 no frame", tx_active, 0);
    cyc(); check("R6 discarded", flag_disc, 1);
    check("R6 still no frame", tx_active, 0);
    clear_all();

    // R7 busy line
    line_busy = 1'b1; send(2'd0, 1); cyc(3);
    check("R7 no flag while busy", flag_disc, 0);
    check("R7 command cleared", send_pending, 0);
    line_busy = 1'b0; cyc();
    check("R7 flag after idle", flag_disc, 1);
    clear_all();

    // R10 pre-emption
    send(2'd0, 4); cyc();
    wr_valid = 1'b1; wr_data = 8'h5C; cyc(); wr_valid = 1'b0;
    hrst_cmd = 1'b1; cyc(); hrst_cmd = 1'b0;
    cyc();
    check("R10 abort", flag_abort, 1);
    check("R10 kind hard reset", tx_kind, 3);
    check("R10 register emptied", byte_valid, 0);
    ser_done = 1'b1; cyc(); ser_done = 1'b0;
    check("R9 hard reset sent", flag_hrst_sent, 1);
    check("R10 no sent", flag_sent, 0);
    clear_all();

    // R11 hard reset discard
    line_busy = 1'b1; hrst_cmd = 1'b1; cyc(); hrst_cmd = 1'b0;
    check("R4 hard reset latched", hrst_pending, 1);
    cyc();
    check("R11 discarded", flag_hrst_disc, 1);
    check("R4 hard reset cleared", hrst_pending, 0);
    line_busy = 1'b0; clear_all();

    // R5 cable reset
    send(2'd1, 0); cyc();
    check("R5 cable reset kind", tx_kind, 1);
    ser_done = 1'b1; cyc(); ser_done = 1'b0;
    check("R9 cable reset sent", flag_sent, 1);

    // R12 BIST runs until disable
    send(2'd2, 0); cyc();
    check("R5 BIST kind", tx_kind, 2);
    ser_done = 1'b1; cyc(); ser_done = 1'b0; cyc(3);
    check("R12 BIST still running", tx_active, 1);
    enable = 1'b0; cyc(); enable = 1'b1;
    check("R12 BIST stopped", tx_active, 0);
    check("R1 flags cleared by disable", flag_sent, 0);

    // R14 hard reset before pending send
    tx_mode = 2'd1; send_cmd = 1'b1; hrst_cmd = 1'b1; cyc();
    send_cmd = 1'b0; hrst_cmd = 1'b0; cyc();
    check("R14 hard reset first", tx_kind, 3);
    check("R14 send still pending", send_pending, 1);
    ser_done = 1'b1; cyc(); ser_done = 1'b0; cyc();
    check("R14 send follows", tx_kind, 1);
    ser_done = 1'b1; cyc(); ser_done = 1'b0;
    clear_all();

    // Mixed traffic against the model
    for (int n = 0; n < 4000; n++) begin
      send_cmd   = ($urandom % 6) == 0;
      hrst_cmd   = ($urandom % 50) == 0;
      tx_mode    = (($urandom % 8) == 0) ? 2'($urandom % 4) : 2'd0;
      pay_size   = 10'($urandom % 6);
      if (($urandom % 10) == 0) line_busy = ~line_busy;
      wr_valid   = $urandom % 2;
      wr_data    = 8'($urandom);
      byte_ready = ($urandom % 3) == 0;
      ser_done   = ($urandom % 12) == 0;
      flag_clr   = (($urandom % 4) == 0) ? 6'($urandom) : 6'd0;
      enable     = ($urandom % 150) != 0;
      cyc();
    end
    cyc(2);
    finish_run();
  end

endmodule